// File: doc/BRIEF.md
# Linear Image Sensor Readout Sequencer

This block controls a two-section linear photodiode array that takes a start pulse and a pixel clock. On a start command it produces the start pulse and a 50 %-duty pixel clock, derived by dividing the system clock. It then clocks one frame out of the array. For every valid pixel it raises a one-cycle strobe toward an external analog-to-digital converter. The converted words come back on a valid/data input. The block tags each word with a pixel index and a section bit, then forwards it.

Integration time is the interval between two start pulses, and the block paces frames to fit it. A requested integration time is clamped into a fixed window. When the array holds charge that is unknown or stale, the block first runs a flush frame with no strobes. This happens after reset, and again whenever more time than the ceiling has passed since the last start pulse. The integration interval is then counted from the flush frame's start pulse.

The two sections can be read in parallel, with one strobe converting both outputs. They can also be read in series, where the second section is chained to the first section's start-out. Timing figures assume a 50 MHz system clock.

Top module: `lsa_readout_seq`

## Requirements
- R1: After reset, pclk_o, si1_o, adc_strobe_o, busy_o, frame_done_o and pix_valid_o are all low.
- R2: The pixel clock half period is H = max(half_div_i, HALF_MIN) system clocks, high and low halves being equal, and pclk_o is low whenever busy_o is low.
- R3: si1_o rises while pclk_o is low and stays high for exactly 2*H cycles, falling together with the first falling edge of pclk_o, so that it spans exactly one rising edge.
- R4: Each start pulse is followed by N+1 rising pixel-clock edges, where N = SEC_PIX when par_mode_i = 1 (parallel) and N = 2*SEC_PIX when par_mode_i = 0 (series).
- R5: A real frame gives exactly N strobes. Each strobe rises D+1 cycles after one of falling edges 1..N, where D = min(strobe_dly_i, H-2). No strobe follows the final falling edge, and a flush frame gives none.
- R6: When a command finds more than INT_MAX cycles elapsed since the last start pulse, a flush frame runs first. This includes every first command after reset.
- R7: The interval between the start pulse of a real frame and the previous start pulse equals clamp(int_req_i, INT_MIN, INT_MAX) when the previous frame ended before that time.
- R8: While busy, si2_o equals si1_o in parallel mode and follows so1_i in series mode.
- R9: A real frame accepts exactly 2*SEC_PIX converter words. Word k is forwarded one cycle later with index k and section 0 in series mode, or with index k/2 and section k mod 2 in parallel mode. Words outside an armed frame are ignored.
- R10: busy_o rises the cycle after a start command and falls when the real frame ends. frame_done_o pulses for one cycle in the first idle cycle. A start command while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start command, one cycle |
| par_mode_i | input | 1 | 1 = sections in parallel, 0 = in series |
| half_div_i | input | DIV_W | Requested pixel-clock half period in system clocks |
| strobe_dly_i | input | DIV_W | Strobe delay after each falling pixel-clock edge |
| int_req_i | input | INT_W | Requested integration time in system clocks |
| so1_i | input | 1 | Start-out of the first section |
| adc_valid_i | input | 1 | Converter word valid |
| adc_data_i | input | DATA_W | Converter word |
| pclk_o | output | 1 | Pixel clock to the array |
| si1_o | output | 1 | Start pulse to the first section |
| si2_o | output | 1 | Start input of the second section |
| adc_strobe_o | output | 1 | Conversion strobe |
| pix_valid_o | output | 1 | Tagged pixel valid |
| pix_data_o | output | DATA_W | Tagged pixel data |
| pix_idx_o | output | IDX_W | Pixel index |
| pix_sec_o | output | 1 | Section bit (parallel mode) |
| busy_o | output | 1 | Command in progress |
| frame_done_o | output | 1 | One-cycle pulse at the end of the real frame |

## Verification
The embedded properties check, cycle by cycle, the local ordering rules. The pixel clock rests low when idle. The start pulse rises only with the clock low and falls only on a falling clock edge. Strobes fall in low halves and never in flush frames. The divider and word counters stay in range, and the done pulse follows busy. Only the bench scenarios can show the counted quantities: the number of edges and strobes per frame, the measured half periods and strobe offsets, the start-to-start interval under clamping, whether a flush frame is inserted after an idle gap longer than the ceiling, and the index and section tags that come back through the converter path.

// File: rtl/lsa_pkg.sv
// Shared types for the linear sensor readout sequencer.
package lsa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } seq_st_t;
endpackage

// File: rtl/lsa_half_timer.sv
// Half-period timer for the pixel clock.
// Counts system clocks while run is high and flags the last cycle of each half.
// Assumes half_len >= 2 and that half_len is stable while run is high.
module lsa_half_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] half_len,
    output logic [W-1:0] cnt,
    output logic         last
);
    logic [W-1:0] cnt_q;

    assign last = run && (cnt_q == half_len - W'(1));
    assign cnt  = cnt_q;

    // Count inside one half period; hold at zero when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (last)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + W'(1);
    end

    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < half_len));
endmodule

// File: rtl/lsa_integ_timer.sv
// Integration timer: counts system clocks since the last start pulse.
// It saturates just above the ceiling, and its reset value is "stale", so the
// first command after reset always sees stale charge. The requested time is
// clamped into [INT_MIN, INT_MAX].
module lsa_integ_timer #(
    parameter int INT_MIN = 1000,
    parameter int INT_MAX = 5_000_000,
    parameter int W       = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] int_req,
    output logic         stale,
    output logic         ready
);
    localparam logic [W-1:0] C_MIN = W'(INT_MIN);
    localparam logic [W-1:0] C_MAX = W'(INT_MAX);
    localparam logic [W-1:0] C_SAT = W'(INT_MAX + 1);

    logic [W-1:0] itmr_q;
    logic [W-1:0] int_eff;

    // Clamp the request into the legal window.
    always_comb begin
        if (int_req < C_MIN)      int_eff = C_MIN;
        else if (int_req > C_MAX) int_eff = C_MAX;
        else                      int_eff = int_req;
    end

    assign stale = itmr_q > C_MAX;
    assign ready = itmr_q >= int_eff;

    // Elapsed-time counter; a restart marks the cycle the start pulse rises.
    always_ff @(posedge clk) begin
        if (!rst_n)
            itmr_q <= C_SAT;
        else if (restart)
            itmr_q <= W'(1);
        else if (itmr_q < C_SAT)
            itmr_q <= itmr_q + W'(1);
    end

    a_r7_clamp_window: assert property (@(posedge clk) disable iff (!rst_n)
        (int_eff >= C_MIN) && (int_eff <= C_MAX));
    a_r6_restart_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !stale);
endmodule

// File: rtl/lsa_pix_tagger.sv
// Tags converter words with pixel index and section bit.
// Armed at each real frame start; it accepts 2*SEC_PIX words, then ignores input.
// Assumes par stays stable for the duration of a frame.
module lsa_pix_tagger #(
    parameter int SEC_PIX = 448,
    parameter int DATA_W  = 12,
    parameter int IDX_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              par,
    input  logic              adc_valid,
    input  logic [DATA_W-1:0] adc_data,
    output logic              pix_valid,
    output logic [DATA_W-1:0] pix_data,
    output logic [IDX_W-1:0]  pix_idx,
    output logic              pix_sec
);
    localparam int TOTAL = 2 * SEC_PIX;
    localparam int CNT_W = $clog2(TOTAL + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;

    // Accept, tag and count words of the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            cnt_q     <= '0;
            pix_valid <= 1'b0;
            pix_data  <= '0;
            pix_idx   <= '0;
            pix_sec   <= 1'b0;
        end else begin
            pix_valid <= 1'b0;
            if (arm) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
            end else if (armed_q && adc_valid) begin
                pix_valid <= 1'b1;
                pix_data  <= adc_data;
                pix_idx   <= par ? IDX_W'(cnt_q >> 1) : IDX_W'(cnt_q);
                pix_sec   <= par & cnt_q[0];
                cnt_q     <= cnt_q + CNT_W'(1);
                if (cnt_q == CNT_W'(TOTAL - 1))
                    armed_q <= 1'b0;
            end
        end
    end

    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (cnt_q < CNT_W'(TOTAL)));
    a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !arm) |=> !pix_valid);
endmodule

// File: rtl/lsa_readout_seq.sv
// Readout sequencer for a two-section linear photodiode array.
// It generates the start pulse and pixel clock, paces frames to the clamped
// integration time, inserts a flush frame when the charge is stale, strobes the
// external converter once per pixel, and tags the returned words.
// Assumes: configuration inputs are stable while busy; HALF_MIN >= 2; a frame
// readout takes fewer cycles than INT_MAX.
module lsa_readout_seq
    import lsa_pkg::*;
#(
    parameter int SEC_PIX  = 448,
    parameter int DATA_W   = 12,
    parameter int DIV_W    = 8,
    parameter int HALF_MIN = 5,
    parameter int INT_MIN  = 1000,
    parameter int INT_MAX  = 5_000_000,
    localparam int IDX_W   = $clog2(2 * SEC_PIX),
    localparam int INT_W   = $clog2(INT_MAX + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              par_mode_i,
    input  logic [DIV_W-1:0]  half_div_i,
    input  logic [DIV_W-1:0]  strobe_dly_i,
    input  logic [INT_W-1:0]  int_req_i,
    input  logic              so1_i,
    input  logic              adc_valid_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic              pclk_o,
    output logic              si1_o,
    output logic              si2_o,
    output logic              adc_strobe_o,
    output logic              pix_valid_o,
    output logic [DATA_W-1:0] pix_data_o,
    output logic [IDX_W-1:0]  pix_idx_o,
    output logic              pix_sec_o,
    output logic              busy_o,
    output logic              frame_done_o
);
    localparam int PER_W = $clog2(2 * SEC_PIX + 2);
    localparam logic [DIV_W-1:0] H_MIN = DIV_W'(HALF_MIN);

    seq_st_t          st_q;
    logic             pclk_q, si_q, dummy_q, mode_q, strobe_q, done_q;
    logic [PER_W-1:0] per_q, n_pix, last_per;
    logic [DIV_W-1:0] h_eff, d_lim, d_eff, hcnt;
    logic             hlast, stale, ready, go_frame;

    // Effective half period, strobe delay and frame length.
    assign h_eff    = (half_div_i < H_MIN) ? H_MIN : half_div_i;
    assign d_lim    = h_eff - DIV_W'(2);
    assign d_eff    = (strobe_dly_i > d_lim) ? d_lim : strobe_dly_i;
    assign n_pix    = mode_q ? PER_W'(SEC_PIX) : PER_W'(2 * SEC_PIX);
    assign last_per = n_pix + PER_W'(1);
    assign go_frame = (st_q == ST_WAIT) && (stale || ready);

    lsa_half_timer #(.W(DIV_W)) u_half (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st_q == ST_SHIFT),
        .half_len (h_eff),
        .cnt      (hcnt),
        .last     (hlast)
    );

    lsa_integ_timer #(.INT_MIN(INT_MIN), .INT_MAX(INT_MAX), .W(INT_W)) u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (go_frame),
        .int_req (int_req_i),
        .stale   (stale),
        .ready   (ready)
    );

    lsa_pix_tagger #(.SEC_PIX(SEC_PIX), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (go_frame && !stale),
        .par       (mode_q),
        .adc_valid (adc_valid_i),
        .adc_data  (adc_data_i),
        .pix_valid (pix_valid_o),
        .pix_data  (pix_data_o),
        .pix_idx   (pix_idx_o),
        .pix_sec   (pix_sec_o)
    );

    // Frame sequencing: idle, integration wait, then clocked shift-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            pclk_q  <= 1'b0;
            si_q    <= 1'b0;
            per_q   <= '0;
            dummy_q <= 1'b0;
            mode_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        mode_q <= par_mode_i;
                        st_q   <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (go_frame) begin
                        st_q    <= ST_SHIFT;
                        si_q    <= 1'b1;
                        dummy_q <= stale;
                        per_q   <= '0;
                        pclk_q  <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (hlast) begin
                        if (!pclk_q) begin
                            pclk_q <= 1'b1;
                            per_q  <= per_q + PER_W'(1);
                        end else begin
                            pclk_q <= 1'b0;
                            si_q   <= 1'b0;
                            if (per_q == last_per) begin
                                st_q   <= dummy_q ? ST_WAIT : ST_IDLE;
                                done_q <= !dummy_q;
                            end
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Conversion strobe: D cycles into low halves 1..N of a real frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            strobe_q <= 1'b0;
        else
            strobe_q <= (st_q == ST_SHIFT) && !pclk_q && !dummy_q &&
                        (per_q != '0) && (hcnt == d_eff);
    end

    assign pclk_o       = pclk_q;
    assign si1_o        = si_q;
    assign si2_o        = mode_q ? si_q : so1_i;
    assign adc_strobe_o = strobe_q;
    assign busy_o       = (st_q != ST_IDLE);
    assign frame_done_o = done_q;

    a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !pclk_o);
    a_r3_si_rise_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(si1_o) |-> !pclk_o);
    a_r3_si_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(si1_o) |-> $fell(pclk_o));
    a_r5_strobe_low: assert property (@(posedge clk) disable iff (!rst_n)
        adc_strobe_o |-> !pclk_o);
    a_r5_no_flush_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        adc_strobe_o |-> !dummy_q);
    a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: tb/sim_lsa_readout_seq.sv
module sim_lsa_readout_seq;
    localparam int SEC     = 4;
    localparam int DATA_W  = 12;
    localparam int DIV_W   = 8;
    localparam int INT_MAX = 300;
    localparam int INT_W   = $clog2(INT_MAX + 2);
    localparam int IDX_W   = $clog2(2 * SEC);

    typedef struct packed {
        logic       par;
        logic [7:0] half;
        logic [7:0] dly;
        logic [8:0] ireq;
        logic [9:0] idle;
        logic       dummy;
        logic [7:0] h_eff;
        logic [7:0] d_eff;
        logic [8:0] i_eff;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd2, 8'd0, 9'd30,  10'd0,   1'b1, 8'd2, 8'd0, 9'd60},
        '{1'b1, 8'd1, 8'd9, 9'd100, 10'd2,   1'b0, 8'd2, 8'd0, 9'd100},
        '{1'b1, 8'd5, 8'd2, 9'd500, 10'd400, 1'b1, 8'd5, 8'd2, 9'd300},
        '{1'b0, 8'd3, 8'd1, 9'd120, 10'd3,   1'b0, 8'd3, 8'd1, 9'd120},
        '{1'b1, 8'd4, 8'd7, 9'd60,  10'd350, 1'b1, 8'd4, 8'd2, 9'd60},
        '{1'b0, 8'd2, 8'd1, 9'd299, 10'd1,   1'b0, 8'd2, 8'd0, 9'd299}
    };

    logic              clk, rst_n, start_i, par_i, so1_i, adc_valid_i;
    logic [DIV_W-1:0]  half_i, dly_i;
    logic [INT_W-1:0]  int_i;
    logic [DATA_W-1:0] adc_data_i;
    logic              pclk_o, si1_o, si2_o, adc_strobe_o, pix_valid_o, pix_sec_o;
    logic              busy_o, frame_done_o;
    logic [DATA_W-1:0] pix_data_o;
    logic [IDX_W-1:0]  pix_idx_o;

    lsa_readout_seq #(.SEC_PIX(SEC), .DATA_W(DATA_W), .DIV_W(DIV_W), .HALF_MIN(2),
                      .INT_MIN(60), .INT_MAX(INT_MAX)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .par_mode_i(par_i),
        .half_div_i(half_i), .strobe_dly_i(dly_i), .int_req_i(int_i),
        .so1_i(so1_i), .adc_valid_i(adc_valid_i), .adc_data_i(adc_data_i),
        .pclk_o(pclk_o), .si1_o(si1_o), .si2_o(si2_o), .adc_strobe_o(adc_strobe_o),
        .pix_valid_o(pix_valid_o), .pix_data_o(pix_data_o), .pix_idx_o(pix_idx_o),
        .pix_sec_o(pix_sec_o), .busy_o(busy_o), .frame_done_o(frame_done_o)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int cyc = 0, n_si, n_prise, n_stb, n_done, si_w_cur, si_w_last, si_t_last = 0;
    int si_gap_last, hi_cur = 0, hi_last, lo_cur = 0, lo_last, t_fall = 0;
    int off_now, off_min, off_max, rx_k, rx_bad, si2_bad, si_hi_bad, idle_clk_bad = 0;
    int word_seq, pend = 0;
    bit prev_pclk = 0, prev_si = 0, prev_stb = 0, inject = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr_mon();
        n_si = 0; n_prise = 0; n_stb = 0; n_done = 0; si_w_last = 0;
        si_gap_last = 0; hi_last = 0; lo_last = 0; off_min = 999; off_max = -1;
        rx_k = 0; rx_bad = 0; si2_bad = 0; si_hi_bad = 0; word_seq = 0;
    endtask

    // Monitor and converter model, all at the falling system-clock edge.
    initial begin
        clr_mon();
        so1_i = 1'b0; adc_valid_i = 1'b0; adc_data_i = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (pclk_o && !prev_pclk) begin n_prise++; lo_last = lo_cur; end
                if (!pclk_o && prev_pclk) begin t_fall = cyc; hi_last = hi_cur; end
                if (pclk_o) hi_cur = prev_pclk ? hi_cur + 1 : 1;
                else        lo_cur = prev_pclk ? 1 : lo_cur + 1;
                if (si1_o && !prev_si) begin
                    n_si++; si_gap_last = cyc - si_t_last; si_t_last = cyc;
                    if (pclk_o) si_hi_bad++;
                    si_w_cur = 1;
                end else if (si1_o) si_w_cur++;
                if (!si1_o && prev_si) si_w_last = si_w_cur;
                if (adc_strobe_o && !prev_stb) begin
                    n_stb++; off_now = cyc - t_fall;
                    if (off_now < off_min) off_min = off_now;
                    if (off_now > off_max) off_max = off_now;
                    pend = par_i ? 2 : 1;
                end
                if (!busy_o && pclk_o) idle_clk_bad++;
                if (busy_o && (par_i ? (si2_o !== si1_o) : (si2_o !== so1_i))) si2_bad++;
                if (pix_valid_o) begin
                    if (pix_idx_o !== IDX_W'(par_i ? rx_k / 2 : rx_k) ||
                        pix_sec_o !== (par_i ? rx_k[0] : 1'b0) ||
                        pix_data_o !== DATA_W'(12'h500 + rx_k)) rx_bad++;
                    rx_k++;
                end
                if (frame_done_o) n_done++;
            end
            prev_pclk = pclk_o; prev_si = si1_o; prev_stb = adc_strobe_o;
            so1_i = ~so1_i;
            if (inject) begin
                adc_valid_i = 1'b1; adc_data_i = 12'hFFF;
            end else if (pend > 0) begin
                adc_valid_i = 1'b1; adc_data_i = DATA_W'(12'h500 + word_seq);
                word_seq++; pend--;
            end else adc_valid_i = 1'b0;
        end
    end

    task automatic wait_done();
        for (int k = 0; k < 4000 && n_done == 0; k++) @(posedge clk);
        repeat (8) @(posedge clk);
        #2;
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(posedge clk); #2;
        start_i = 1'b0;
    endtask

    task automatic poke_word();
        inject = 1'b1;
        @(posedge clk); #2;
        inject = 1'b0;
        repeat (3) @(posedge clk);
        #2;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; par_i = 1'b0;
        half_i = 8'd2; dly_i = '0; int_i = 9'd60;
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;
        // R1 reset state
        chk(!pclk_o && !si1_o, "R1 clock/start low", {pclk_o, si1_o}, 0);
        chk(!adc_strobe_o && !busy_o, "R1 strobe/busy low", {adc_strobe_o, busy_o}, 0);
        chk(!pix_valid_o && !frame_done_o, "R1 valid/done low", {pix_valid_o, frame_done_o}, 0);
        // R9 word before any frame is ignored
        poke_word();
        chk(rx_k == 0, "R9 word outside frame ignored", rx_k, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int   n;
            v = VECS[i];
            n = v.par ? SEC : 2 * SEC;
            repeat (int'(v.idle)) @(posedge clk);
            #2;
            par_i = v.par; half_i = v.half; dly_i = v.dly; int_i = v.ireq;
            clr_mon();
            pulse_start();
            chk(busy_o, "R10 busy after start", busy_o, 1);
            wait_done();
            chk(hi_last == int'(v.h_eff) && lo_last == int'(v.h_eff),
                "R2 half period", hi_last * 100 + lo_last, int'(v.h_eff) * 101);
            chk(si_w_last == 2 * int'(v.h_eff) && si_hi_bad == 0,
                "R3 start pulse width", si_w_last, 2 * int'(v.h_eff));
            chk(n_prise == (v.dummy ? 2 : 1) * (n + 1), "R4 rising edges",
                n_prise, (v.dummy ? 2 : 1) * (n + 1));
            chk(n_stb == n, "R5 strobe count", n_stb, n);
            chk(off_min == int'(v.d_eff) + 1 && off_max == int'(v.d_eff) + 1,
                "R5 strobe offset", off_max, int'(v.d_eff) + 1);
            chk(n_si == (v.dummy ? 2 : 1), "R6 flush frame inserted", n_si, v.dummy ? 2 : 1);
            chk(si_gap_last == int'(v.i_eff), "R7 integration interval",
                si_gap_last, int'(v.i_eff));
            chk(si2_bad == 0, "R8 second section start", si2_bad, 0);
            chk(rx_k == 2 * SEC && rx_bad == 0, "R9 tagged words", rx_k * 100 + rx_bad, 2 * SEC * 100);
            chk(n_done == 1 && !busy_o, "R10 done pulse", n_done, 1);
        end

        // R9 words after a complete frame are ignored
        poke_word();
        chk(rx_k == 2 * SEC, "R9 extra word ignored", rx_k, 2 * SEC);

        // R10 start while busy is ignored
        par_i = 1'b1; half_i = 8'd2; dly_i = '0; int_i = 9'd100;
        clr_mon();
        pulse_start();
        repeat (10) @(posedge clk);
        #2;
        pulse_start();
        wait_done();
        repeat (150) @(posedge clk);
        #2;
        chk(n_si == 1 && n_done == 1, "R10 second start ignored", n_si * 10 + n_done, 11);
        chk(!busy_o && !pclk_o, "R10 idle after frame", {busy_o, pclk_o}, 0);
        chk(idle_clk_bad == 0, "R2 clock low when idle", idle_clk_bad, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule